// File: doc/BRIEF.md
# Pseudo-Random Link Self-Test Checker

This block is the receiving end of a built-in link test. Upstream logic hands it one decoded symbol at a time: an 8-bit value plus a flag that marks it as a special (control) code rather than data. While the active-low test enable is held high the checker stays silent. Once the enable is pulled low, the checker hunts for the loop marker, which is the data symbol with value 0x00. The marker locks it to the far-end generator.

After lock, a local 9-bit LFSR predicts each following symbol of the 511-symbol loop. The checker compares every accepted symbol with that prediction. It raises a one-cycle violation pulse for each symbol that differs, and a one-cycle ready pulse each time a full loop has passed. The prediction covers the data codes, the special codes and the deliberate code violations the generator emits. All of them are treated as plain 9-bit patterns.

The symbol input is a valid/ready stream. The checker never applies back-pressure: `sym_ready` is always high, and a symbol is consumed in every cycle in which `sym_valid` is high. The enable travels with the symbol stream and is evaluated in the same cycle as the symbol beside it.

Top module: `link_selftest_checker`

## Requirements
- R1: `sym_ready` is high in every cycle, so every cycle with `sym_valid` high consumes exactly one symbol.
- R2: During and right after reset, `mismatch` and `loop_done` are low, and the checker is hunting for the marker.
- R3: While `test_en_n` is high, `mismatch` and `loop_done` stay low for any input, including the marker, and the checker returns to hunting.
- R4: While hunting with `test_en_n` low, only a consumed symbol with `sym_special`=0 and `sym_data`=0x00 gives lock. Every other symbol, including special 0x00, is ignored and raises no pulse.
- R5: The predicted symbol is {`sym_special`,`sym_data`} = S XOR 9'h001, where S is a 9-bit state. S is 9'h001 at the marker, and each consumed symbol steps S to {S[7:0], S[8]^S[4]}, which gives a loop of 511 symbols.
- R6: In lock, a consumed symbol that differs from the prediction in any data bit or in the special flag produces `mismatch` high for exactly the next cycle.
- R7: `loop_done` is high for one cycle after the 511th consumed symbol of each loop, counting the marker as the first. This is the symbol just before the next marker is due.
- R8: Cycles with `sym_valid` low neither advance the prediction nor raise any pulse.
- R9: A mismatch does not resynchronise the checker. Later correct symbols in their expected positions raise no `mismatch`.
- R10: Raising `test_en_n` during lock drops the lock. After it is lowered again, sequence symbols other than the marker raise no pulse until a new marker arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en_n | input | 1 | Self-test enable, active low, aligned with the symbol |
| sym_valid | input | 1 | Symbol present this cycle |
| sym_ready | output | 1 | Always high; the checker never stalls |
| sym_special | input | 1 | 1 = special/control code, 0 = data |
| sym_data | input | 8 | Decoded symbol value |
| loop_done | output | 1 | One-cycle pulse per completed 511-symbol loop |
| mismatch | output | 1 | One-cycle pulse per symbol that differs from prediction |

## Verification
A corrupted LFSR state appears as a `mismatch` pulse one cycle after the next consumed symbol, and the pulses keep coming on nearly every symbol after that. A wrong loop position counter moves or removes `loop_done` pulses, which the bench sees within one loop of 511 symbols. A hunting or lock flag stuck in the wrong state shows up as pulses while the checker should be silent, or as no detection of a deliberately corrupted symbol. The bench compares every cycle against a behavioural model, so each of these faults is caught at the first affected clock.

// File: rtl/lst_pkg.sv
package lst_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_RUN  = 1'b1
  } lst_state_e;
endpackage

// File: rtl/lst_lfsr.sv
module lst_lfsr #(
  parameter int              W    = 9,
  parameter int              TAP  = 5,
  parameter logic [W-1:0]    SEED = 9'h001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] state
);
  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], s[W-1] ^ s[TAP-1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (load) state <= step(SEED);
    else if (adv)  state <= step(state);
  end

  assert_state_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/lst_ctrl.sv
module lst_ctrl
  import lst_pkg::*;
#(
  parameter int LOOP_LEN = 511,
  parameter int CNT_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en_n,
  input  logic             sym_valid,
  input  logic             is_marker,
  input  logic             sym_equal,
  output logic             load,
  output logic             adv,
  output lst_state_e       st,
  output logic [CNT_W-1:0] pos,
  output logic             loop_done,
  output logic             mismatch
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOOP_LEN - 1);

  always_comb begin
    load = !test_en_n && (st == ST_HUNT) && sym_valid && is_marker;
    adv  = !test_en_n && (st == ST_RUN) && sym_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_HUNT;
      pos       <= '0;
      loop_done <= 1'b0;
      mismatch  <= 1'b0;
    end else begin
      loop_done <= 1'b0;
      mismatch  <= 1'b0;
      if (test_en_n) begin
        st  <= ST_HUNT;
        pos <= '0;
      end else if (load) begin
        st  <= ST_RUN;
        pos <= CNT_W'(1);
      end else if (adv) begin
        mismatch <= !sym_equal;
        if (pos == LAST) begin
          pos       <= '0;
          loop_done <= 1'b1;
        end else begin
          pos <= pos + CNT_W'(1);
        end
      end
    end
  end

  assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    test_en_n |=> (!mismatch && !loop_done && st == ST_HUNT));
  assert_hunt_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT) |=> (!mismatch && !loop_done));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_valid && !test_en_n) |=> ($stable(pos) && !mismatch && !loop_done));
  assert_loop_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_done) |-> ($past(pos) == LAST && pos == '0));
endmodule

// File: rtl/link_selftest_checker.sv
module link_selftest_checker
  import lst_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter int TAP   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_en_n,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic             sym_special,
  input  logic [SYM_W-1:0] sym_data,
  output logic             loop_done,
  output logic             mismatch
);
  localparam int               LFSR_W   = SYM_W + 1;
  localparam int               LOOP_LEN = (1 << LFSR_W) - 1;
  localparam int               CNT_W    = $clog2(LOOP_LEN);
  localparam logic [LFSR_W-1:0] SEED    = LFSR_W'(1);

  logic [LFSR_W-1:0] lfsr_state;
  logic [CNT_W-1:0]  pos;
  lst_state_e        st;
  logic              load, adv, is_marker, sym_equal;

  assign sym_ready = 1'b1;
  assign is_marker = !sym_special && (sym_data == '0);
  assign sym_equal = ({sym_special, sym_data} == (lfsr_state ^ SEED));

  lst_lfsr #(.W(LFSR_W), .TAP(TAP), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .state(lfsr_state)
  );

  lst_ctrl #(.LOOP_LEN(LOOP_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .test_en_n(test_en_n), .sym_valid(sym_valid),
    .is_marker(is_marker), .sym_equal(sym_equal), .load(load), .adv(adv),
    .st(st), .pos(pos), .loop_done(loop_done), .mismatch(mismatch)
  );

  assert_loop_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && pos == '0) |-> (lfsr_state == SEED));
  assert_lock_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (st == ST_RUN && pos == CNT_W'(1)));
endmodule

// File: tb/link_selftest_checker_bench.sv
module link_selftest_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       test_en_n = 1'b1;
  logic       sym_valid = 1'b0;
  logic       sym_special = 1'b0;
  logic [7:0] sym_data = 8'h00;
  logic       sym_ready, loop_done, mismatch;

  int checks = 0, failures = 0, cyc = 0;
  int ld_seen = 0, mm_seen = 0;
  bit m_run = 0;
  int m_st = 1, m_pos = 0;
  int tx_st = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_selftest_checker u_link_selftest_checker (
    .clk(clk), .rst_n(rst_n), .test_en_n(test_en_n), .sym_valid(sym_valid),
    .sym_ready(sym_ready), .sym_special(sym_special), .sym_data(sym_data),
    .loop_done(loop_done), .mismatch(mismatch)
  );

  function automatic int nxt(int s);
    int fb;
    fb = ((s >> 8) ^ (s >> 4)) & 1;
    return ((s << 1) | fb) & 511;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, MAX_CYC);
      finish_run();
    end
  end

  // one cycle: drive, advance model, compare after the edge
  task automatic step(input bit v, input bit sp, input logic [7:0] d, input bit en_n,
                      input string tag);
    bit e_mm, e_ld;
    int sym;
    @(negedge clk);
    sym_valid = v; sym_special = sp; sym_data = d; test_en_n = en_n;
    e_mm = 0; e_ld = 0;
    sym = (int'(sp) << 8) | int'(d);
    if (en_n) begin
      m_run = 0;
    end else if (!m_run) begin
      if (v && sym == 0) begin
        m_run = 1; m_pos = 1; m_st = nxt(1);
      end
    end else if (v) begin
      e_mm = (sym != (m_st ^ 1));
      e_ld = (m_pos == 510);
      m_pos = (m_pos == 510) ? 0 : m_pos + 1;
      m_st = nxt(m_st);
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1", sym_ready, 1'b1, "sym_ready");
    chk(tag, mismatch, e_mm, "mismatch");
    chk(tag, loop_done, e_ld, "loop_done");
    if (loop_done) ld_seen++;
    if (mismatch) mm_seen++;
  endtask

  task automatic send_tx(input bit en_n, input int flip, input string tag);
    int s;
    s = (tx_st ^ 1) ^ flip;
    step(1'b1, s[8], s[7:0], en_n, tag);
    tx_st = nxt(tx_st);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R2", mismatch, 1'b0, "mismatch in reset");
    chk("R2", loop_done, 1'b0, "loop_done in reset");
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, 8'h00, 1'b1, "R2");

    // R3: enable high, full traffic including marker
    tx_st = 1;
    for (int i = 0; i < 40; i++) send_tx(1'b1, 0, "R3");

    // R4: hunting, near-marker symbols ignored
    step(1'b1, 1'b1, 8'h00, 1'b0, "R4");
    step(1'b1, 1'b0, 8'h01, 1'b0, "R4");
    step(1'b1, 1'b0, 8'h80, 1'b0, "R4");
    step(1'b0, 1'b0, 8'h00, 1'b0, "R4");

    // R5/R7/R8: lock, two full loops with gaps, then next marker
    tx_st = 1; ld_seen = 0; mm_seen = 0;
    for (int i = 0; i < 1023; i++) begin
      if (i % 37 == 5) step(1'b0, 1'b1, 8'hAA, 1'b0, "R8");
      send_tx(1'b0, 0, "R5");
    end
    chk("R7", 1'(ld_seen == 2), 1'b1, "two loop_done pulses over two loops");
    chk("R5", 1'(mm_seen == 0), 1'b1, "no mismatch on clean loops");

    // R6/R9: corrupt a data bit and the special flag, keep running
    mm_seen = 0;
    for (int i = 0; i < 511; i++) begin
      if (i == 100)      send_tx(1'b0, 9'h010, "R6");
      else if (i == 200) send_tx(1'b0, 9'h100, "R6");
      else               send_tx(1'b0, 0, "R9");
    end
    chk("R6", 1'(mm_seen == 2), 1'b1, "two corrupted symbols flagged");

    // R10: drop enable mid-loop, resume without marker, then relock
    for (int i = 0; i < 3; i++) send_tx(1'b1, 0, "R10");
    mm_seen = 0;
    for (int i = 0; i < 40; i++) send_tx(1'b0, 0, "R10");
    send_tx(1'b0, 9'h0F0, "R10");
    chk("R10", 1'(mm_seen == 0), 1'b1, "no pulse before new marker");
    tx_st = 1;
    for (int i = 0; i < 20; i++) send_tx(1'b0, 0, "R10");
    send_tx(1'b0, 9'h003, "R6");
    chk("R10", 1'(mm_seen == 1), 1'b1, "relocked after marker");

    finish_run();
  end
endmodule